// File: doc/BRIEF.md
# Serial Control Register File

This block is the write-only configuration port of a multichannel audio converter. A host moves 16-bit command words in over three wires: a shift clock, a data line and a separate latch strobe. Each word names one of nine 10-bit registers and carries the value for it. Three of these registers are control registers. The other six set the attenuation of each output channel. The stored values are decoded into individual field outputs that the audio path uses. These are de-emphasis curve, serial input format, sample word length, power-down, interpolation ratio, per-channel mutes, stereo replication, master-clock ratio, zero-flag polarity and six volume levels.

The serial pins are sampled by the block's system clock, which must run well above the shift clock. A word is committed only when the latch strobe rises after exactly sixteen shift-clock rising edges. Any other count throws the word away. The power-down field is staged. A committed value becomes visible only at the next rising edge of the latch strobe, so the host writes that command twice.

Top module: `spi_ctrl_regs`

## Requirements
- R1: While reset is asserted and directly after it, every field output is zero except the six volume levels, which are all ones (1023).
- R2: Bits are taken on rising edges of `ser_clk`, most significant bit first. A rising edge of `ser_latch` that follows exactly 16 such edges commits the word. Bits 15..12 form the address and bits 9..0 form the data. Bits 11..10 are not used.
- R3: A word whose latch edge follows fewer or more than 16 shift-clock edges changes no register. The shift count restarts after every latch edge.
- R4: Address 0 sets `deemph_sel` from data bits 9..8, `serial_fmt` from 7..5, `word_len` from 4..3 and `interp_sel` from 1..0.
- R5: Data bit 2 at address 0 is held pending. `power_down` takes the pending value on the next rising latch edge, whether or not that edge commits a valid word.
- R6: Address 1 sets `mute` from data bits 5..0. Bit 0 controls channel 1 and bit 5 controls channel 6. Data bits 9..6 are ignored.
- R7: Address 8 sets `replicate` from data bit 5, `mclk_ratio` from bits 4..3 and `zero_act_low` from bit 2.
- R8: Addresses 2 through 7 write the volume of channels 1 through 6. Channel c (1..6) appears on `volume[10*c-1 : 10*(c-1)]`.
- R9: A committed word with an address from 9 to 15 changes no output.
- R10: Outputs other than `power_down` change only in the cycle after a committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial command data, MSB first |
| ser_latch | input | 1 | Commit strobe, acts on its rising edge |
| deemph_sel | output | 2 | De-emphasis curve: 0 off, 1 44.1 kHz, 2 32 kHz, 3 48 kHz |
| serial_fmt | output | 3 | Serial audio input format code |
| word_len | output | 2 | Sample width: 0 24 bits, 1 20 bits, 2 16 bits |
| power_down | output | 1 | Staged power-down request |
| interp_sel | output | 2 | Interpolation: 0 x8, 1 x2, 2 x4 |
| mute | output | 6 | Per-channel mute, bit 0 is channel 1 |
| replicate | output | 1 | Copy channel 1 stereo data to channels 2 and 3 |
| mclk_ratio | output | 2 | Master clock: 0 256, 1 512, 2 768 times sample rate |
| zero_act_low | output | 1 | Zero-flag polarity, 1 selects active low |
| volume | output | 60 | Six 10-bit linear volume levels, all ones is full scale |

## Verification
The hardest case to reach is the staged power-down. The pending value must move to the output on a latch edge that itself commits nothing. The stimulus sets the bit and confirms the output has not moved. It then clears the bit and sends a 15-bit word with its own latch edge, and checks that power-down falls while all other fields hold. A 17-bit word is also sent whose last 16 bits form a valid volume write. This shows that the count, and not the content of the shift register, decides whether a word is committed.

// File: rtl/spi_ctrl_regs.sv
`timescale 1ns/1ps
module spi_ctrl_regs #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10,
  parameter int N_CH   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk,
  input  logic                     ser_data,
  input  logic                     ser_latch,
  output logic [1:0]               deemph_sel,
  output logic [2:0]               serial_fmt,
  output logic [1:0]               word_len,
  output logic                     power_down,
  output logic [1:0]               interp_sel,
  output logic [N_CH-1:0]          mute,
  output logic                     replicate,
  output logic [1:0]               mclk_ratio,
  output logic                     zero_act_low,
  output logic [N_CH*DATA_W-1:0]   volume
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [ADDR_W-1:0] A_CTL1 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTL2 = ADDR_W'(1);
  localparam int VOL_BASE = 2;
  localparam logic [ADDR_W-1:0] A_CTL3 = ADDR_W'(VOL_BASE + N_CH);

  logic sclk_q, sclk_qq, sd_q, lat_q, lat_qq;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              pd_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sclk_q, sclk_qq, sd_q, lat_q, lat_qq} <= '0;
    else        {sclk_q, sclk_qq, sd_q, lat_q, lat_qq} <= {ser_clk, sclk_q, ser_data, ser_latch, lat_q};

  wire sclk_rise = sclk_q & ~sclk_qq;
  wire lat_rise  = lat_q & ~lat_qq;
  wire word_ok   = lat_rise && (cnt == CNT_FULL);
  wire [ADDR_W-1:0] addr = shreg[WORD_W-1 -: ADDR_W];
  wire [DATA_W-1:0] dat  = shreg[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (lat_rise) begin
      cnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[WORD_W-2:0], sd_q};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      deemph_sel <= '0;
      serial_fmt <= '0;
      word_len   <= '0;
      interp_sel <= '0;
      pd_pend    <= 1'b0;
      power_down <= 1'b0;
    end else if (lat_rise) begin
      power_down <= pd_pend;
      if (word_ok && addr == A_CTL1) begin
        deemph_sel <= dat[9:8];
        serial_fmt <= dat[7:5];
        word_len   <= dat[4:3];
        pd_pend    <= dat[2];
        interp_sel <= dat[1:0];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          mute <= '0;
    else if (word_ok && addr == A_CTL2)  mute <= dat[N_CH-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      replicate    <= 1'b0;
      mclk_ratio   <= '0;
      zero_act_low <= 1'b0;
    end else if (word_ok && addr == A_CTL3) begin
      replicate    <= dat[5];
      mclk_ratio   <= dat[4:3];
      zero_act_low <= dat[2];
    end

  for (genvar c = 0; c < N_CH; c++) begin : g_vol
    logic [DATA_W-1:0] lvl;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                          lvl <= '1;
      else if (word_ok && addr == ADDR_W'(VOL_BASE + c))   lvl <= dat;
    assign volume[c*DATA_W +: DATA_W] = lvl;
  end

  wire [N_CH*DATA_W+N_CH+13:0] cfg_bus =
    {deemph_sel, serial_fmt, word_len, interp_sel, mute, replicate, mclk_ratio, zero_act_low, volume};

  a_r10_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !word_ok |=> $stable(cfg_bus));
  a_r3_bad_count_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && cnt != CNT_FULL) |=> $stable(cfg_bus));
  a_r9_reserved_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && addr > A_CTL3) |=> $stable(cfg_bus));
  a_r5_pd_on_latch_only: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rise |=> $stable(power_down));
  a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    lat_rise |=> (cnt == '0));
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !lat_rise && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/spi_ctrl_regs_test.sv
`timescale 1ns/1ps
module spi_ctrl_regs_test;
  logic clk = 0, rst_n = 0, sclk = 0, sd = 0, lat = 0;
  logic [1:0] deemph_sel, word_len, interp_sel, mclk_ratio;
  logic [2:0] serial_fmt;
  logic power_down, replicate, zero_act_low;
  logic [5:0] mute;
  logic [59:0] volume;
  int checks = 0, failures = 0, cycles = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  spi_ctrl_regs uut (.clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_data(sd), .ser_latch(lat),
    .deemph_sel(deemph_sel), .serial_fmt(serial_fmt), .word_len(word_len), .power_down(power_down),
    .interp_sel(interp_sel), .mute(mute), .replicate(replicate), .mclk_ratio(mclk_ratio),
    .zero_act_low(zero_act_low), .volume(volume));

  // behavioural reference: edges seen on sampled pins, acted on one clock later
  int m_de, m_fmt, m_wl, m_pd, m_pend, m_int, m_mute, m_rep, m_mck, m_zp;
  int m_vol[6];
  logic [15:0] m_sh;
  int m_cnt;
  logic p1c, p2c, p1d, p1l, p2l;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_de = 0; m_fmt = 0; m_wl = 0; m_pd = 0; m_pend = 0; m_int = 0;
      m_mute = 0; m_rep = 0; m_mck = 0; m_zp = 0; m_cnt = 0; m_sh = 0;
      foreach (m_vol[i]) m_vol[i] = 1023;
      p1c = 0; p2c = 0; p1d = 0; p1l = 0; p2l = 0;
    end else begin
      if (p1l && !p2l) begin
        m_pd = m_pend;
        if (m_cnt == 16) begin
          int a, d;
          a = int'(m_sh[15:12]); d = int'(m_sh[9:0]);
          if (a == 0) begin
            m_de = d >> 8; m_fmt = (d >> 5) & 7; m_wl = (d >> 3) & 3;
            m_pend = (d >> 2) & 1; m_int = d & 3;
          end else if (a == 1) m_mute = d & 63;
          else if (a >= 2 && a <= 7) m_vol[a-2] = d;
          else if (a == 8) begin
            m_rep = (d >> 5) & 1; m_mck = (d >> 3) & 3; m_zp = (d >> 2) & 1;
          end
        end
        m_cnt = 0;
      end else if (p1c && !p2c) begin
        m_sh = {m_sh[14:0], p1d};
        m_cnt++;
      end
      p2c = p1c; p2l = p1l; p1c = sclk; p1d = sd; p1l = lat;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_on) begin
    chk("R4 deemph (model)", deemph_sel, m_de);
    chk("R4 serial_fmt (model)", serial_fmt, m_fmt);
    chk("R4 word_len (model)", word_len, m_wl);
    chk("R4 interp (model)", interp_sel, m_int);
    chk("R5 power_down (model)", power_down, m_pd);
    chk("R6 mute (model)", mute, m_mute);
    chk("R7 replicate (model)", replicate, m_rep);
    chk("R7 mclk_ratio (model)", mclk_ratio, m_mck);
    chk("R7 zero_act_low (model)", zero_act_low, m_zp);
    for (int c = 0; c < 6; c++) chk("R8 volume (model)", volume[c*10 +: 10], m_vol[c]);
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic shift_bits(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sd = w[i]; tick(2); sclk = 1; tick(2); sclk = 0;
    end
  endtask
  task automatic strobe(); lat = 1; tick(2); lat = 0; tick(4); endtask
  task automatic write16(logic [15:0] w); shift_bits(32'(w), 16); strobe(); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 reset power_down", power_down, 0);
    chk("R1 reset mute", mute, 0);
    chk("R1 reset volume ch1", volume[9:0], 1023);
    chk("R1 reset volume ch6", volume[59:50], 1023);
    rst_n = 1; tick(2); cmp_on = 1;
    chk("R1 after reset deemph", deemph_sel, 0);

    write16(16'h0276);
    chk("R4 deemph", deemph_sel, 2);
    chk("R4 serial_fmt", serial_fmt, 3);
    chk("R4 word_len", word_len, 2);
    chk("R4 interp", interp_sel, 2);
    chk("R5 pd not yet applied", power_down, 0);

    write16(16'h1021);
    chk("R5 pd applied on next latch", power_down, 1);
    chk("R6 mute ch1 and ch6", mute, 6'b100001);

    write16(16'h0272);
    chk("R5 pd still set", power_down, 1);
    shift_bits(32'h0000_4155 >> 1, 15); strobe();
    chk("R5 pd cleared by non-committing latch", power_down, 0);
    chk("R3 short word dropped vol ch3", volume[29:20], 1023);
    chk("R3 short word keeps mute", mute, 6'b100001);

    write16(16'h8034);
    chk("R7 replicate", replicate, 1);
    chk("R7 mclk_ratio", mclk_ratio, 2);
    chk("R7 zero_act_low", zero_act_low, 1);

    write16(16'h4155);
    write16(16'h7000);
    chk("R8 volume ch3", volume[29:20], 341);
    chk("R8 volume ch6", volume[59:50], 0);
    chk("R8 volume ch1 untouched", volume[9:0], 1023);

    shift_bits(32'h0000_3155, 17); strobe();
    chk("R3 long word dropped vol ch2", volume[19:10], 1023);
    write16(16'h3155);
    chk("R2 count restarts after latch vol ch2", volume[19:10], 341);

    write16(16'h9FFF);
    write16(16'hF3FF);
    chk("R9 reserved addr keeps mute", mute, 6'b100001);
    chk("R9 reserved addr keeps deemph", deemph_sel, 2);
    chk("R9 reserved addr keeps vol ch6", volume[59:50], 0);

    write16(16'h13C0);
    chk("R6 reserved data bits ignored", mute, 0);

    shift_bits(32'h0000_2AAA, 16); tick(10);
    chk("R10 no change before latch vol ch1", volume[9:0], 1023);
    strobe();
    chk("R2 MSB-first word commits vol ch1", volume[9:0], 10'h2AA);

    tick(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule